// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block holds the hazard-control logic of a five-stage in-order integer pipeline with 32-bit fixed-format instructions. It looks at the instruction word sitting in the decode stage and at the destination index, register-write flag and load flag of the three later pipeline registers: decode-to-execute, execute-to-memory and memory-to-writeback. From these it chooses the execute-stage operand sources, steers the decode-stage branch comparator, and decides when to hold fetch and decode. It also decides when to squash the instruction fetched behind a taken branch or jump. Every output is combinational.

The datapath takes the forward selects into its execute-stage operand muxes. It uses `stall` to keep the PC and the fetch/decode register and to load a bubble into the decode/execute register. `dec_wr` goes low under a stall, so the write-enable that goes into that register is already cleared. `flush` clears the fetch/decode register. The register file is taken to be write-first: a value written back is visible to a decode-stage read in the same cycle.

Top module: `hzd_unit`

## Requirements
- R1: The opcode is bits 31:26. Opcode 0x00 reads bits 25:21 and 20:16 and writes bits 15:11. Opcode 0x23 (load) and opcodes 0x08 to 0x0F (immediate ALU) read bits 25:21 and write bits 20:16. Opcode 0x2B (store), 0x04 (branch if equal) and 0x05 (branch if not equal) read both source fields and write nothing. Opcode 0x02 (jump) and every other opcode read and write nothing. `dec_dst` shows the written index, or 0 when nothing is written, and `dec_wr` is 1 exactly when a nonzero register is written and `stall` is 0.
- R2: When the execute/memory stage writes a nonzero register equal to an execute-stage source index, that operand's select is 2'b10.
- R3: When only the memory/writeback stage writes a nonzero register equal to the source index, the select is 2'b01. With no match the select is 2'b00.
- R4: When both later stages match the same source, the select is 2'b10, because the newer value wins.
- R5: A pending write to register 0 never produces a forward select other than 2'b00 and never raises `stall`.
- R6: A load in execute whose nonzero destination equals a register read by the decode instruction raises `stall` for that cycle.
- R7: While `stall` is 1, `dec_wr` is 0 and `flush` is 0, whatever the decode instruction is.
- R8: `flush` is 1 for a jump, for a branch-if-equal with `br_eq_id`=1, and for a branch-if-not-equal with `br_eq_id`=0. In all other cases it is 0.
- R9: A branch in decode stalls when a source matches a write pending in execute, or a load in memory. When a source matches a non-load write in memory, it does not stall and sets `brfwd_a` (first source) or `brfwd_b` (second source).
- R10: Only read-after-write hazards stall. Matches against memory/writeback, a matching destination that the decode instruction does not read, and a matching non-load in execute before a non-branch all leave `stall` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_id | input | 32 | Instruction word in decode |
| br_eq_id | input | 1 | Equality result of the decode-stage comparator |
| idx_rs | input | 5 | First source index of the instruction in execute |
| idx_rt | input | 5 | Second source index of the instruction in execute |
| idx_dst | input | 5 | Destination index held in decode/execute |
| idx_wr | input | 1 | Register-write flag in decode/execute |
| idx_ld | input | 1 | Load flag in decode/execute |
| exm_dst | input | 5 | Destination index held in execute/memory |
| exm_wr | input | 1 | Register-write flag in execute/memory |
| exm_ld | input | 1 | Load flag in execute/memory |
| mwb_dst | input | 5 | Destination index held in memory/writeback |
| mwb_wr | input | 1 | Register-write flag in memory/writeback |
| fwd_a | output | 2 | First execute operand source: 00 file, 10 exec/mem, 01 mem/wb |
| fwd_b | output | 2 | Second execute operand source, same encoding |
| brfwd_a | output | 1 | Branch comparator first input taken from exec/mem |
| brfwd_b | output | 1 | Branch comparator second input taken from exec/mem |
| stall | output | 1 | Hold PC and fetch/decode, insert bubble |
| flush | output | 1 | Squash the instruction in fetch/decode |
| dec_dst | output | 5 | Destination index of the decode instruction |
| dec_wr | output | 1 | Register-write enable for decode/execute, cleared on stall |

## Verification
The assertions take the load flag of a pipeline register as a subset of its write flag, because a load always writes. They also assume that inputs change only between evaluations and never part-way through a check. The bench keeps the load flag set only together with the write flag in every vector. It drives all inputs of one pattern in a single step, then waits before sampling the outputs.

// File: rtl/hzd_pkg.sv
`timescale 1ns/1ps
package hzd_pkg;
  localparam int INSTR_W = 32;
  localparam int RADDR_W = 5;
  localparam int OP_W    = 6;
  localparam int OP_LSB  = INSTR_W - OP_W;
  localparam int RS_LSB  = OP_LSB - RADDR_W;
  localparam int RT_LSB  = RS_LSB - RADDR_W;
  localparam int RD_LSB  = RT_LSB - RADDR_W;

  typedef logic [RADDR_W-1:0] reg_idx_t;
  typedef logic [OP_W-1:0]    opc_t;

  localparam opc_t OPC_RR    = 6'h00;
  localparam opc_t OPC_JMP   = 6'h02;
  localparam opc_t OPC_BEQ   = 6'h04;
  localparam opc_t OPC_BNE   = 6'h05;
  localparam opc_t OPC_LOAD  = 6'h23;
  localparam opc_t OPC_STORE = 6'h2B;
  localparam opc_t OPC_IMM_LO = 6'h08;
  localparam opc_t OPC_IMM_HI = 6'h0F;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;

  typedef struct packed {
    reg_idx_t rs;
    reg_idx_t rt;
    reg_idx_t dst;
    logic     use_rs;
    logic     use_rt;
    logic     has_dst;
    logic     is_br;
    logic     br_on_ne;
    logic     is_jmp;
  } dec_info_t;

  function automatic logic is_imm_alu(input opc_t op);
    return (op >= OPC_IMM_LO) && (op <= OPC_IMM_HI);
  endfunction

  // a read of src collides with a pending write of dst
  function automatic logic raw_hit(input reg_idx_t src, input logic used,
                                   input reg_idx_t dst, input logic wr);
    return used && wr && (dst != '0) && (dst == src);
  endfunction

  function automatic fwd_sel_e pick_fwd(input reg_idx_t src,
                                        input reg_idx_t m_dst, input logic m_wr,
                                        input reg_idx_t w_dst, input logic w_wr);
    if (raw_hit(src, 1'b1, m_dst, m_wr)) return FWD_MEM;
    if (raw_hit(src, 1'b1, w_dst, w_wr)) return FWD_WB;
    return FWD_RF;
  endfunction
endpackage

// File: rtl/hzd_decode.sv
`timescale 1ns/1ps
module hzd_decode
  import hzd_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_info_t          info
);
  opc_t     op;
  reg_idx_t f_rd;
  logic     wr_fmt;
  reg_idx_t dst_fmt;

  assign op   = instr[OP_LSB +: OP_W];
  assign f_rd = instr[RD_LSB +: RADDR_W];

  always_comb begin
    info        = '0;
    info.rs     = instr[RS_LSB +: RADDR_W];
    info.rt     = instr[RT_LSB +: RADDR_W];
    wr_fmt      = 1'b0;
    dst_fmt     = '0;
    case (op)
      OPC_RR: begin
        info.use_rs = 1'b1;
        info.use_rt = 1'b1;
        wr_fmt      = 1'b1;
        dst_fmt     = f_rd;
      end
      OPC_LOAD: begin
        info.use_rs = 1'b1;
        wr_fmt      = 1'b1;
        dst_fmt     = info.rt;
      end
      OPC_STORE: begin
        info.use_rs = 1'b1;
        info.use_rt = 1'b1;
      end
      OPC_BEQ, OPC_BNE: begin
        info.use_rs   = 1'b1;
        info.use_rt   = 1'b1;
        info.is_br    = 1'b1;
        info.br_on_ne = (op == OPC_BNE);
      end
      OPC_JMP: info.is_jmp = 1'b1;
      default: begin
        if (is_imm_alu(op)) begin
          info.use_rs = 1'b1;
          wr_fmt      = 1'b1;
          dst_fmt     = info.rt;
        end
      end
    endcase
    info.has_dst = wr_fmt && (dst_fmt != '0);
    info.dst     = info.has_dst ? dst_fmt : '0;
  end
endmodule

// File: rtl/hzd_fwd_sel.sv
`timescale 1ns/1ps
module hzd_fwd_sel
  import hzd_pkg::*;
(
  input  reg_idx_t src,
  input  reg_idx_t m_dst,
  input  logic     m_wr,
  input  reg_idx_t w_dst,
  input  logic     w_wr,
  output fwd_sel_e sel
);
  assign sel = pick_fwd(src, m_dst, m_wr, w_dst, w_wr);
endmodule

// File: rtl/hzd_stall_ctl.sv
`timescale 1ns/1ps
module hzd_stall_ctl
  import hzd_pkg::*;
(
  input  dec_info_t info,
  input  logic      br_eq,
  input  reg_idx_t  idx_dst,
  input  logic      idx_wr,
  input  logic      idx_ld,
  input  reg_idx_t  exm_dst,
  input  logic      exm_wr,
  input  logic      exm_ld,
  output logic      lu_hit,
  output logic      br_hold,
  output logic [1:0] br_fwd,
  output logic      stall,
  output logic      flush
);
  logic [1:0] hit_ex, hit_mem_ld, hit_mem_alu;
  reg_idx_t   src   [2];
  logic       used  [2];
  logic       taken;

  assign src[0]  = info.rs;
  assign src[1]  = info.rt;
  assign used[0] = info.use_rs;
  assign used[1] = info.use_rt;

  for (genvar g = 0; g < 2; g++) begin : g_src
    assign hit_ex[g]      = raw_hit(src[g], used[g], idx_dst, idx_wr);
    assign hit_mem_ld[g]  = raw_hit(src[g], used[g], exm_dst, exm_wr & exm_ld);
    assign hit_mem_alu[g] = raw_hit(src[g], used[g], exm_dst, exm_wr & ~exm_ld);
    assign br_fwd[g]      = info.is_br & hit_mem_alu[g];
  end

  assign lu_hit  = idx_ld & (|hit_ex);
  assign br_hold = info.is_br & ((|hit_ex) | (|hit_mem_ld));
  assign stall   = lu_hit | br_hold;
  assign taken   = info.is_jmp | (info.is_br & (br_eq ^ info.br_on_ne));
  assign flush   = taken & ~stall;
endmodule

// File: rtl/hzd_unit.sv
`timescale 1ns/1ps
module hzd_unit
  import hzd_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_id,
  input  logic               br_eq_id,
  input  logic [RADDR_W-1:0] idx_rs,
  input  logic [RADDR_W-1:0] idx_rt,
  input  logic [RADDR_W-1:0] idx_dst,
  input  logic               idx_wr,
  input  logic               idx_ld,
  input  logic [RADDR_W-1:0] exm_dst,
  input  logic               exm_wr,
  input  logic               exm_ld,
  input  logic [RADDR_W-1:0] mwb_dst,
  input  logic               mwb_wr,
  output logic [1:0]         fwd_a,
  output logic [1:0]         fwd_b,
  output logic               brfwd_a,
  output logic               brfwd_b,
  output logic               stall,
  output logic               flush,
  output logic [RADDR_W-1:0] dec_dst,
  output logic               dec_wr
);
  localparam int N_OPND = 2;

  dec_info_t  info;
  reg_idx_t   ex_src [N_OPND];
  fwd_sel_e   ex_sel [N_OPND];
  logic       lu_hit;
  logic       br_hold;
  logic [1:0] br_fwd;

  hzd_decode u_dec (.instr(instr_id), .info(info));

  assign ex_src[0] = idx_rs;
  assign ex_src[1] = idx_rt;

  for (genvar g = 0; g < N_OPND; g++) begin : g_fwd
    hzd_fwd_sel u_sel (
      .src  (ex_src[g]),
      .m_dst(exm_dst),
      .m_wr (exm_wr),
      .w_dst(mwb_dst),
      .w_wr (mwb_wr),
      .sel  (ex_sel[g])
    );
  end

  hzd_stall_ctl u_hz (
    .info   (info),
    .br_eq  (br_eq_id),
    .idx_dst(idx_dst),
    .idx_wr (idx_wr),
    .idx_ld (idx_ld),
    .exm_dst(exm_dst),
    .exm_wr (exm_wr),
    .exm_ld (exm_ld),
    .lu_hit (lu_hit),
    .br_hold(br_hold),
    .br_fwd (br_fwd),
    .stall  (stall),
    .flush  (flush)
  );

  assign fwd_a   = ex_sel[0];
  assign fwd_b   = ex_sel[1];
  assign brfwd_a = br_fwd[0];
  assign brfwd_b = br_fwd[1];
  assign dec_dst = info.dst;
  assign dec_wr  = info.has_dst & ~stall;
endmodule

// File: rtl/hzd_unit_chk.sv
`timescale 1ns/1ps
module hzd_unit_chk
  import hzd_pkg::*;
(
  input logic [INSTR_W-1:0] instr_id,
  input logic [RADDR_W-1:0] idx_rs,
  input logic [RADDR_W-1:0] idx_rt,
  input logic [RADDR_W-1:0] idx_dst,
  input logic               idx_wr,
  input logic               idx_ld,
  input logic [RADDR_W-1:0] exm_dst,
  input logic               exm_wr,
  input logic [RADDR_W-1:0] mwb_dst,
  input logic               mwb_wr,
  input logic [1:0]         fwd_a,
  input logic [1:0]         fwd_b,
  input logic               stall,
  input logic               flush,
  input logic               dec_wr,
  input logic               lu_hit
);
  opc_t op;
  assign op = instr_id[OP_LSB +: OP_W];

  always_comb begin
    // R2
    if (fwd_a == 2'b10)
      fwd_mem_src_chk: assert (exm_wr && exm_dst != '0 && exm_dst == idx_rs);
    // R4
    if (exm_wr && exm_dst != '0 && exm_dst == idx_rt)
      fwd_prio_chk: assert (fwd_b == 2'b10);
    // R5
    if (exm_dst == '0 && mwb_dst == '0)
      zero_reg_chk: assert (fwd_a == 2'b00 && fwd_b == 2'b00);
    // R6
    if (lu_hit)
      lu_src_chk: assert (idx_ld && idx_wr && idx_dst != '0 && stall);
    // R7
    if (stall)
      bubble_chk: assert (!dec_wr && !flush);
    // R8
    if (flush)
      flush_op_chk: assert (op == OPC_BEQ || op == OPC_BNE || op == OPC_JMP);
    // R10
    if (!idx_wr && !exm_wr)
      no_raw_stall_chk: assert (!stall);
  end
endmodule

bind hzd_unit hzd_unit_chk i_chk (
  .instr_id(instr_id), .idx_rs(idx_rs), .idx_rt(idx_rt), .idx_dst(idx_dst),
  .idx_wr(idx_wr), .idx_ld(idx_ld), .exm_dst(exm_dst), .exm_wr(exm_wr),
  .mwb_dst(mwb_dst), .mwb_wr(mwb_wr), .fwd_a(fwd_a), .fwd_b(fwd_b),
  .stall(stall), .flush(flush), .dec_wr(dec_wr), .lu_hit(lu_hit)
);

// File: tb/test_hzd_unit.sv
`timescale 1ns/1ps
module test_hzd_unit;
  localparam int CLK_HALF = 2.5;

  typedef struct packed {
    logic [31:0] instr; logic breq;
    logic [4:0] irs; logic [4:0] irt; logic [4:0] idst; logic iwr; logic ild;
    logic [4:0] xdst; logic xwr; logic xld;
    logic [4:0] wdst; logic wwr;
    logic [1:0] fa; logic [1:0] fb; logic bfa; logic bfb;
    logic st; logic fl; logic [4:0] dd; logic dw;
  } vec_t;

  function automatic logic [31:0] rr(input logic [4:0] s, input logic [4:0] t, input logic [4:0] d);
    return {6'h00, s, t, d, 11'h000};
  endfunction
  function automatic logic [31:0] it(input logic [5:0] op, input logic [4:0] s, input logic [4:0] t);
    return {op, s, t, 16'h0010};
  endfunction

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{32'h0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0},   // idle, R1
    '{rr(1,2,3), 1'b0, 5'd4, 5'd5, 5'd0, 1'b0, 1'b0, 5'd4, 1'b1, 1'b0, 5'd0, 1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 5'd3, 1'b1}, // R2
    '{rr(1,2,3), 1'b0, 5'd6, 5'd7, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd7, 1'b1, 2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 5'd3, 1'b1}, // R3
    '{rr(1,2,3), 1'b0, 5'd8, 5'd8, 5'd0, 1'b0, 1'b0, 5'd8, 1'b1, 1'b0, 5'd8, 1'b1, 2'b10, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 5'd3, 1'b1}, // R4
    '{rr(1,2,3), 1'b0, 5'd9, 5'd0, 5'd0, 1'b0, 1'b0, 5'd9, 1'b0, 1'b0, 5'd9, 1'b1, 2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 5'd3, 1'b1}, // R3
    '{rr(0,0,0), 1'b0, 5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 1'b0, 5'd0, 1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0}, // R5
    '{rr(10,11,12), 1'b0, 5'd0, 5'd0, 5'd10, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 5'd12, 1'b0}, // R6 R7
    '{it(6'h2B,13,14), 1'b0, 5'd0, 5'd0, 5'd14, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0, 1'b0}, // R6
    '{it(6'h08,15,16), 1'b0, 5'd0, 5'd0, 5'd16, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 5'd16, 1'b1}, // R10
    '{rr(10,11,12), 1'b0, 5'd0, 5'd0, 5'd10, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 5'd12, 1'b1}, // R10
    '{it(6'h04,1,2), 1'b1, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0, 1'b0}, // R8
    '{it(6'h04,1,2), 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0}, // R8
    '{it(6'h05,1,2), 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0, 1'b0}, // R8
    '{{6'h02,26'h40}, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0, 1'b0}, // R8
    '{it(6'h04,3,4), 1'b1, 5'd0, 5'd0, 5'd3, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0, 1'b0}, // R9
    '{it(6'h04,3,4), 1'b1, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd4, 1'b1, 1'b1, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0, 1'b0}, // R9
    '{it(6'h04,3,4), 1'b1, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd4, 1'b1, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 5'd0, 1'b0}, // R9
    '{it(6'h04,3,4), 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd3, 1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0}, // R10
    '{it(6'h23,5,6), 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 5'd6, 1'b1}, // R1
    '{it(6'h0F,7,9), 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 5'd9, 1'b1}, // R1
    '{it(6'h3F,5,6), 1'b0, 5'd0, 5'd0, 5'd5, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0}, // R1
    '{it(6'h08,1,0), 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0}, // R5
    '{it(6'h04,3,4), 1'b1, 5'd0, 5'd0, 5'd4, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0, 1'b0}  // R7
  };

  logic clk = 1'b0;
  always #(CLK_HALF) clk = ~clk;

  logic [31:0] instr_id;
  logic br_eq_id, idx_wr, idx_ld, exm_wr, exm_ld, mwb_wr;
  logic [4:0] idx_rs, idx_rt, idx_dst, exm_dst, mwb_dst;
  logic [1:0] fwd_a, fwd_b;
  logic brfwd_a, brfwd_b, stall, flush, dec_wr;
  logic [4:0] dec_dst;

  int n_chk = 0;
  int n_bad = 0;

  hzd_unit i_hzd_unit (
    .instr_id(instr_id), .br_eq_id(br_eq_id), .idx_rs(idx_rs), .idx_rt(idx_rt),
    .idx_dst(idx_dst), .idx_wr(idx_wr), .idx_ld(idx_ld), .exm_dst(exm_dst),
    .exm_wr(exm_wr), .exm_ld(exm_ld), .mwb_dst(mwb_dst), .mwb_wr(mwb_wr),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .brfwd_a(brfwd_a), .brfwd_b(brfwd_b),
    .stall(stall), .flush(flush), .dec_dst(dec_dst), .dec_wr(dec_wr)
  );

  task automatic apply_check(input vec_t v, input string tag);
    logic [13:0] act, exp;
    @(negedge clk);
    instr_id = v.instr; br_eq_id = v.breq;
    idx_rs = v.irs; idx_rt = v.irt; idx_dst = v.idst; idx_wr = v.iwr; idx_ld = v.ild;
    exm_dst = v.xdst; exm_wr = v.xwr; exm_ld = v.xld;
    mwb_dst = v.wdst; mwb_wr = v.wwr;
    #1;
    act = {fwd_a, fwd_b, brfwd_a, brfwd_b, stall, flush, dec_dst, dec_wr};
    exp = {v.fa, v.fb, v.bfa, v.bfb, v.st, v.fl, v.dd, v.dw};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got fa/fb/bfa/bfb/st/fl/dst/wr=%b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    vec_t v;
    // idle pipeline, as after reset: R1 R5
    apply_check(VEC[0], "R1 idle");
    for (int i = 1; i < NV; i++) apply_check(VEC[i], $sformatf("vector %0d", i));
    // R2 R5: execute/memory match across every register index
    for (int r = 0; r < 32; r++) begin
      v = VEC[0];
      v.irs = 5'(r); v.xdst = 5'(r); v.xwr = 1'b1;
      v.fa = (r == 0) ? 2'b00 : 2'b10;
      apply_check(v, $sformatf("R2 fwd reg %0d", r));
    end
    // R6 R5: load-use across every register index
    for (int r = 0; r < 32; r++) begin
      v = VEC[0];
      v.instr = rr(5'(r), 5'd0, 5'd1);
      v.idst = 5'(r); v.iwr = 1'b1; v.ild = 1'b1;
      v.st = (r != 0); v.dd = 5'd1; v.dw = (r == 0);
      apply_check(v, $sformatf("R6 load-use reg %0d", r));
    end
    // R3: memory/writeback only, across every index
    for (int r = 1; r < 32; r++) begin
      v = VEC[0];
      v.irt = 5'(r); v.wdst = 5'(r); v.wwr = 1'b1; v.xdst = 5'(r); v.xwr = 1'b0;
      v.fb = 2'b01;
      apply_check(v, $sformatf("R3 wb reg %0d", r));
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule